// File: doc/BRIEF.md
# Soft Mute Attenuation Ramp

This block fades an audio sample stream in and out without stopping it. It holds an applied attenuation level and scales each incoming sample by a gain derived from that level. When a mute request is raised, the level steps down one code at a time until it reaches full mute, where the output is exactly zero. When the request is dropped, the level steps back up to the programmed attenuation code. A release that comes partway through the fade reverses the direction at once. The level then climbs back from wherever it stands, at the same rate.

The ramp is paced by a frame strobe. The level moves one code per step interval, and the interval depends on the speed mode. The fade therefore lasts the same wall-clock time at every sample rate. The programmed code is also followed gradually while the stream is not muted, so any change to it is heard as a smooth transition rather than a jump. Filtering, interpolation and modulation happen elsewhere in the chain.

Top module: `smute_ramp`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `level` is 0 (full mute) and `sample_vld` is 0.
- R2: `level` changes by exactly one code per step, and only on a clock edge where `frame_stb` is high.
- R3: While `mute_req` is 1, the target is 0. `level` falls by one code each time a step interval of frame strobes completes, and stays at 0 once it gets there.
- R4: While `mute_req` is 0, the target is `att_code`. `level` rises by one code per completed interval until it equals that code.
- R5: If `mute_req` falls before `level` reaches 0, the next step moves `level` upward from its current value. The strobe count already gathered toward the next step is kept, so the rate does not change.
- R6: The step interval is 14 frame strobes for `speed_mode` 2'b00, 28 for 2'b01, and 56 for 2'b10 or 2'b11. The first step happens on the interval-th strobe after the level last matched its target.
- R7: A change of `att_code` while unmuted, in either direction, is followed one code per interval, never as a jump.
- R8: Each output sample is round((sample_in × g) / 256), with ties rounded toward +∞. Here g = level + level[7], so code 255 gives unity and passes the sample unchanged, and code 0 gives exactly 0. The result is saturated to 24 bits.
- R9: `sample_vld` is high for exactly one cycle after each clock edge on which `frame_stb` was high. The sample is scaled by the level that was in effect before that edge's update.
- R10: When `frame_stb` is low, `level` and the step count do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mute_req | input | 1 | 1 requests a fade to full mute |
| att_code | input | 8 | Programmed attenuation code, 255 = 0 dB, 0 = mute |
| speed_mode | input | 2 | 00 normal, 01 double, 10/11 quad |
| frame_stb | input | 1 | One-cycle strobe per frame, qualifies `sample_in` |
| sample_in | input | 24 | Signed input sample |
| sample_out | output | 24 | Signed scaled sample, registered |
| sample_vld | output | 1 | Qualifies `sample_out` |
| level | output | 8 | Currently applied attenuation code |

## Verification
The fade is exercised with several patterns. A full fade-in from reset, a full fade-out and a mute released at level 155 show whether the step count, the direction and the turnaround point are correct. Runs in double and quad speed separate the three interval lengths from one another. Retargeting `att_code` up and down while unmuted, and holding `frame_stb` low for a stretch, show that steps depend only on strobes. Samples include both 24-bit extremes and small negative values at non-unity levels, which exposes errors in rounding direction and in the unity gain at code 255.

// File: rtl/smute_pkg.sv
package smute_pkg;
  typedef enum logic [1:0] {
    SPD_NORMAL = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_QUAD_B = 2'b11
  } speed_e;

  // Interval multiplier exponent per speed mode
  function automatic int unsigned speed_shift(speed_e s);
    case (s)
      SPD_NORMAL: return 0;
      SPD_DOUBLE: return 1;
      default:    return 2;
    endcase
  endfunction
endpackage

// File: rtl/smute_pacer.sv
module smute_pacer
  import smute_pkg::*;
#(
  parameter int BASE_IV = 14,
  localparam int MAX_IV = BASE_IV * 4,
  localparam int CNT_W  = $clog2(MAX_IV + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stb,
  input  logic       busy,
  input  logic [1:0] speed,
  output logic       step
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit = CNT_W'(BASE_IV << speed_shift(speed_e'(speed)));
    step  = stb && busy && (cnt >= limit - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (stb) begin
      if (!busy || step) cnt <= '0;
      else               cnt <= cnt + CNT_W'(1);
    end
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(MAX_IV));

  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(stb) |-> $stable(cnt));
endmodule

// File: rtl/smute_track.sv
module smute_track #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic             mute,
  input  logic [LVL_W-1:0] att,
  input  logic             step,
  output logic [LVL_W-1:0] lvl,
  output logic             busy
);
  logic [LVL_W-1:0] tgt;

  always_comb begin
    tgt  = mute ? '0 : att;
    busy = (lvl != tgt);
  end

  always_ff @(posedge clk) begin
    if (rst)       lvl <= '0;
    else if (step) lvl <= (lvl < tgt) ? lvl + LVL_W'(1) : lvl - LVL_W'(1);
  end

  // R2
  level_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(lvl) |-> (lvl == $past(lvl) + LVL_W'(1) || lvl == $past(lvl) - LVL_W'(1)));

  // R10
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(stb) |-> $stable(lvl));

  // R3
  mute_down_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mute) && !$stable(lvl)) |-> lvl == $past(lvl) - LVL_W'(1));
endmodule

// File: rtl/smute_scale.sv
module smute_scale #(
  parameter int SMP_W = 24,
  parameter int LVL_W = 8,
  localparam int PW   = SMP_W + LVL_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    stb,
  input  logic        [LVL_W-1:0] lvl,
  input  logic signed [SMP_W-1:0] din,
  output logic signed [SMP_W-1:0] dout,
  output logic                    dvld
);
  logic        [LVL_W:0]     gain;
  logic signed [PW-1:0]      din_x, gain_x, prod, rnd, shr;
  logic        [PW-SMP_W:0]  upper;
  logic signed [SMP_W-1:0]   sat;

  always_comb begin
    gain   = {1'b0, lvl} + {{LVL_W{1'b0}}, lvl[LVL_W-1]};
    din_x  = PW'(din);
    gain_x = $signed({{(PW-LVL_W-1){1'b0}}, gain});
    prod   = din_x * gain_x;
    rnd    = prod + $signed(PW'(1) << (LVL_W - 1));
    shr    = rnd >>> LVL_W;
    upper  = shr[PW-1:SMP_W-1];
    if (&upper || ~|upper) sat = shr[SMP_W-1:0];
    else                   sat = {shr[PW-1], {(SMP_W-1){~shr[PW-1]}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      dvld <= 1'b0;
    end else begin
      dvld <= stb;
      if (stb) dout <= sat;
    end
  end

  // R8
  mute_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(stb) && $past(lvl) == '0) |-> dout == '0);

  // R8
  unity_pass_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(stb) && $past(lvl) == '1) |-> dout == $past(din));

  // R9
  vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dvld |-> $past(stb));
endmodule

// File: rtl/smute_ramp.sv
module smute_ramp #(
  parameter int SMP_W   = 24,
  parameter int LVL_W   = 8,
  parameter int BASE_IV = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mute_req,
  input  logic        [LVL_W-1:0] att_code,
  input  logic        [1:0]       speed_mode,
  input  logic                    frame_stb,
  input  logic signed [SMP_W-1:0] sample_in,
  output logic signed [SMP_W-1:0] sample_out,
  output logic                    sample_vld,
  output logic        [LVL_W-1:0] level
);
  logic step, busy;

  smute_pacer #(.BASE_IV(BASE_IV)) u_pacer (
    .clk(clk), .rst(rst), .stb(frame_stb), .busy(busy),
    .speed(speed_mode), .step(step)
  );

  smute_track #(.LVL_W(LVL_W)) u_track (
    .clk(clk), .rst(rst), .stb(frame_stb), .mute(mute_req),
    .att(att_code), .step(step), .lvl(level), .busy(busy)
  );

  smute_scale #(.SMP_W(SMP_W), .LVL_W(LVL_W)) u_scale (
    .clk(clk), .rst(rst), .stb(frame_stb), .lvl(level),
    .din(sample_in), .dout(sample_out), .dvld(sample_vld)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (level == '0 && !sample_vld));
endmodule

// File: tb/smute_ramp_test.sv
module smute_ramp_test;
  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               mute_req = 1'b0;
  logic [7:0]         att_code = 8'd255;
  logic [1:0]         speed_mode = 2'b00;
  logic               frame_stb = 1'b0;
  logic signed [23:0] sample_in = '0;
  logic signed [23:0] sample_out;
  logic               sample_vld;
  logic [7:0]         level;

  int checks = 0, failures = 0;
  int m_lvl = 0, m_cnt = 0;
  int exp_out_q[$];
  int exp_lvl_q[$];
  string tag = "R1";
  int unsigned seed = 32'h1234_5678;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smute_ramp uut (
    .clk(clk), .rst(rst), .mute_req(mute_req), .att_code(att_code),
    .speed_mode(speed_mode), .frame_stb(frame_stb), .sample_in(sample_in),
    .sample_out(sample_out), .sample_vld(sample_vld), .level(level)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int scale_ref(int s, int l);
    longint g = l + (l >= 128 ? 1 : 0);
    longint p = longint'(s) * g + 128;
    longint r = p >>> 8;
    if (r > 8388607) r = 8388607;
    if (r < -8388608) r = -8388608;
    return int'(r);
  endfunction

  function automatic int next_sample();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[31:8]));
  endfunction

  // Driver: one frame strobe (or idle cycle) and model prediction
  task automatic drive(bit stb, int smp);
    int iv, tgt;
    @(negedge clk);
    frame_stb = stb;
    sample_in = 24'(smp);
    if (stb) begin
      exp_out_q.push_back(scale_ref(smp, m_lvl));
      iv  = 14 << (speed_mode == 2'b00 ? 0 : speed_mode == 2'b01 ? 1 : 2);
      tgt = mute_req ? 0 : int'(att_code);
      if (m_lvl == tgt) m_cnt = 0;
      else if (m_cnt >= iv - 1) begin
        m_cnt = 0;
        m_lvl += (m_lvl < tgt) ? 1 : -1;
      end else m_cnt++;
      exp_lvl_q.push_back(m_lvl);
    end
  endtask

  task automatic frames(int n);
    for (int i = 0; i < n; i++) drive(1'b1, next_sample());
  endtask

  task automatic settle();
    drive(1'b0, 0);
  endtask

  // Monitor: compare each produced sample and level against the queue
  always @(posedge clk) begin
    #1;
    if (!rst && sample_vld) begin
      if (exp_out_q.size() == 0) chk("R9 unexpected sample_vld", 1, 0);
      else begin
        chk({tag, " R8 sample"}, int'(sample_out), exp_out_q.pop_front());
        chk({tag, " R2 level"}, int'(level), exp_lvl_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 level in reset", int'(level), 0);
    chk("R1 vld in reset", int'(sample_vld), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 level after reset", int'(level), 0);

    // R4 fade in from reset to 255
    tag = "R4";
    frames(13);
    settle();
    chk("R6 no step before 14th strobe", int'(level), 0);
    frames(1);
    settle();
    chk("R6 step at 14th strobe", int'(level), 1);
    frames(254 * 14);
    settle();
    chk("R4 reached target", int'(level), 255);

    // R8 unity passes extremes
    tag = "R8";
    drive(1'b1, 8388607);
    drive(1'b1, -8388608);
    drive(1'b1, -1);
    settle();

    // R5 mute released partway
    tag = "R5";
    mute_req = 1'b1;
    frames(100 * 14);
    settle();
    chk("R3 partial fade level", int'(level), 155);
    frames(7);
    mute_req = 1'b0;
    frames(7);
    settle();
    chk("R5 turnaround climbs", int'(level), 156);
    frames(99 * 14);
    settle();
    chk("R5 back at target", int'(level), 255);

    // R3 full fade out
    tag = "R3";
    mute_req = 1'b1;
    frames(255 * 14 + 30);
    settle();
    chk("R3 full mute level", int'(level), 0);
    drive(1'b1, 8388607);
    settle();

    // R6 speed modes
    tag = "R6";
    mute_req = 1'b0;
    speed_mode = 2'b01;
    frames(3 * 28);
    settle();
    chk("R6 double speed steps", int'(level), 3);
    speed_mode = 2'b10;
    frames(2 * 56 - 1);
    settle();
    chk("R6 quad speed not yet", int'(level), 4);
    frames(1);
    settle();
    chk("R6 quad speed steps", int'(level), 5);

    // R10 no strobes, no change
    tag = "R10";
    for (int i = 0; i < 60; i++) drive(1'b0, next_sample());
    chk("R10 level held", int'(level), 5);

    // R7 retarget while unmuted
    tag = "R7";
    speed_mode = 2'b00;
    att_code = 8'd130;
    frames(125 * 14);
    settle();
    chk("R7 up to new code", int'(level), 130);
    att_code = 8'd100;
    frames(14);
    settle();
    chk("R7 single step down", int'(level), 129);
    frames(29 * 14 + 5);
    settle();
    chk("R7 down to new code", int'(level), 100);
    for (int i = 0; i < 8; i++) drive(1'b1, -(i * 37 + 1));
    settle();
    settle();
    chk("R9 queue drained", exp_out_q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule